// File: doc/BRIEF.md
# ARINC 429 Receive Channel with Label Filter

This block receives one two-wire ARINC 429 channel. It samples the two differential legs after they have been brought to logic levels, and it finds the return-to-zero bit pulses and the Null gaps between words. It rebuilds each 32-bit word, putting the label bits, which arrive most significant bit first, back into their natural positions. A word that completes is screened in three ways, each switched on by its own control bit:

- the parity of bit 32;
- the two source/destination bits;
- membership of its label in a small table that the host loads.

A word that passes every enabled screen goes into a receive FIFO. The FIFO has empty, level and full flags and an interrupt.

The host uses four registers, chosen by a 2-bit select:
- Data: a read pops the oldest word.
- Control: read and write.
- Status: read only.
- Label: a read or write moves through the table with its own auto-incrementing read pointer and write pointer.

Writing the control register with its reload bit set returns both pointers to zero. From then on, only the labels written after the reload take part in the comparison.

Top module: `a429_label_rx`

## Requirements
- R1: A bit is decoded as 1 when leg A is high and leg B is low, and as 0 when A is low and B is high. Each bit counts once, on leaving the Null state (both legs low). The first eight bits received are label bits 8 down to 1, and later bits fill word bits 9 to 32 in order. Word bit n appears at data register bit n-1.
- R2: A state with both legs high is ignored. It neither adds a bit nor ends the Null state that comes before the next bit.
- R3: Null lasting at least three bit times clears the bit counter and discards any partial word.
- R4: Control bit 0 selects the bit time used for gap timing: 0 selects FAST_BIT_CLKS clock cycles (100 kbps) and 1 selects SLOW_BIT_CLKS clock cycles (low speed).
- R5: With control bit 2 set, bit 32 is parity. Control bit 3 selects the parity: 0 requires an odd count of ones over all 32 bits and 1 requires an even count. A word that fails is dropped.
- R6: With control bit 4 set, a word is kept only if word bit 9 equals control bit 5 and word bit 10 equals control bit 6.
- R7: With control bit 1 set, a word is kept only if its label (bits 1 to 8) equals an entry written since the last reload. With control bit 1 clear, no label check is made.
- R8: Writing the control register with bit 7 set resets both label pointers to zero. Bit 7 reads back as 0.
- R9: Each label write stores one entry and advances the write pointer. Writes beyond LABELS entries are ignored. Each label read returns the entry at the read pointer and advances it.
- R10: The FIFO returns words in arrival order. Status bit 0 is empty, bit 1 is count at or above FIFO_LEVEL, and bit 2 is full. The same flags appear on ports, and rx_irq is high while any flag is high.
- R11: A word that completes while the FIFO is full is dropped, and the stored contents are unchanged.
- R12: The select values are 0 = data, 1 = control, 2 = status and 3 = label. Read data appears on reg_rdata in the cycle after the read strobe. Reading data while the FIFO is empty returns 0. After reset the control register is 0, the FIFO is empty and rx_irq is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| leg_a | input | 1 | Line leg A, logic level, asynchronous |
| leg_b | input | 1 | Line leg B, logic level, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 8 | Write data for control or label |
| reg_rdata | output | 32 | Registered read data |
| rx_empty | output | 1 | FIFO empty |
| rx_level | output | 1 | FIFO at or above the programmed level |
| rx_full | output | 1 | FIFO full |
| rx_irq | output | 1 | Receive interrupt |

## Verification
The bench targets the following corner cases:
- **Label order.** Words are chosen so that the label byte is not symmetric. A design that kept the label in wire order would return a bit-reversed label.
- **Broken words.** A partial word is followed by a long gap, and a word is sent with both-high glitches between its bits. A receiver that missed the gap would merge the fragment into the next word, and one that treated the glitch as a bit or as the end of Null would corrupt or lose the word.
- **Label table.** The table is checked just past its capacity and again after a reload. A wrong design would match stale labels, or let a write past the end overwrite an entry.
- **Parity, SDI, slow rate and overflow.** Parity is tested in both senses and each SDI bit on its own, because an inverted sense or swapped SDI bits would flip accept and reject. Low-speed words are sent with gaps between bits that are longer than three fast bit times. A word is sent into a full FIFO, where it must be dropped without disturbing the stored order.

// File: rtl/a429_pkg.sv
// Shared types for the ARINC 429 receive channel.
// Assumes: the control register is 8 bits, held in the order below.
package a429_pkg;

    typedef enum logic [1:0] {
        SEL_DATA  = 2'd0,
        SEL_CTRL  = 2'd1,
        SEL_STAT  = 2'd2,
        SEL_LABEL = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic reload;    // bit 7: pointer reset strobe, not stored
        logic sdi10;     // bit 6: required value of word bit 10
        logic sdi9;      // bit 5: required value of word bit 9
        logic sdi_en;    // bit 4
        logic par_even;  // bit 3
        logic par_en;    // bit 2
        logic lbl_en;    // bit 1
        logic slow;      // bit 0
    } rx_ctrl_t;

endpackage

// File: rtl/a429_line_decoder.sv
// Line decoder: synchronises both legs, detects return-to-zero bits,
// times Null gaps and assembles 32-bit words in natural bit order.
// Assumes: at least a few clocks per half bit; leg state 11 is invalid.
module a429_line_decoder #(
    parameter int FAST_BIT_CLKS = 100,
    parameter int SLOW_BIT_CLKS = 800
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        slow,
    input  logic        leg_a,
    input  logic        leg_b,
    output logic [31:0] word,
    output logic        word_vld
);
    localparam int GAP_FAST = 3 * FAST_BIT_CLKS;
    localparam int GAP_SLOW = 3 * SLOW_BIT_CLKS;
    localparam int GMAX     = (GAP_SLOW > GAP_FAST) ? GAP_SLOW : GAP_FAST;
    localparam int GW       = $clog2(GMAX + 1);

    logic [1:0]    sync_a, sync_b;
    logic [1:0]    cur, last;
    logic [GW-1:0] gap, gap_lim;
    logic [4:0]    cnt, idx;
    logic [31:0]   shreg, asm_word;
    logic          bit_evt;

    // Two-stage synchronisers for the asynchronous legs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_a <= '0;
            sync_b <= '0;
        end else begin
            sync_a <= {sync_a[0], leg_a};
            sync_b <= {sync_b[0], leg_b};
        end
    end

    assign cur     = {sync_a[1], sync_b[1]};
    assign bit_evt = ((cur == 2'b10) || (cur == 2'b01)) && (last == 2'b00);
    assign gap_lim = slow ? GW'(GAP_SLOW) : GW'(GAP_FAST);

    // Place the new bit: the first eight arrive as label bits 8..1.
    always_comb begin
        idx      = (cnt < 5'd8) ? (5'd7 - cnt) : cnt;
        asm_word = shreg;
        asm_word[idx] = cur[1];
    end

    // Gap timing, bit counting and word completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last     <= 2'b00;
            gap      <= '0;
            cnt      <= '0;
            shreg    <= '0;
            word     <= '0;
            word_vld <= 1'b0;
        end else begin
            word_vld <= 1'b0;
            if (cur != 2'b11) last <= cur;
            if (cur == 2'b00) begin
                if (gap != gap_lim) gap <= gap + 1'b1;
                else                cnt <= '0;
            end else if (cur != 2'b11) begin
                gap <= '0;
            end
            if (bit_evt) begin
                shreg <= asm_word;
                if (cnt == 5'd31) begin
                    word     <= asm_word;
                    word_vld <= 1'b1;
                    cnt      <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/a429_label_table.sv
// Label table: host-loaded list of 8-bit labels with auto-incrementing
// write and read pointers, and a parallel match against a probe label.
// Assumes: LABELS >= 1; entries at or above the write pointer never match.
module a429_label_table #(
    parameter int LABELS = 16,
    parameter int PW     = $clog2(LABELS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reload,
    input  logic          wr,
    input  logic [7:0]    wdata,
    input  logic          rd,
    output logic [7:0]    rdata,
    input  logic [7:0]    probe,
    output logic          hit,
    output logic [PW-1:0] wr_ptr
);
    localparam int AW = (LABELS > 1) ? $clog2(LABELS) : 1;

    logic [7:0]        mem [LABELS];
    logic [AW-1:0]     rd_ptr;
    logic [LABELS-1:0] match;

    // Pointer maintenance; reload has priority over access.
    always_ff @(posedge clk) begin
        if (!rst_n || reload) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (wr && (wr_ptr < PW'(LABELS))) wr_ptr <= wr_ptr + 1'b1;
            if (rd) rd_ptr <= (rd_ptr == AW'(LABELS - 1)) ? '0 : rd_ptr + 1'b1;
        end
    end

    // Entry storage, written only while space remains.
    always_ff @(posedge clk) begin
        if (rst_n && !reload && wr && (wr_ptr < PW'(LABELS)))
            mem[wr_ptr[AW-1:0]] <= wdata;
    end

    assign rdata = mem[rd_ptr];

    // One comparator per entry, masked by the valid count.
    for (genvar i = 0; i < LABELS; i++) begin : g_cmp
        assign match[i] = (PW'(i) < wr_ptr) && (mem[i] == probe);
    end
    assign hit = |match;
endmodule

// File: rtl/a429_word_fifo.sv
// Word FIFO with empty, programmed-level and full flags.
// Assumes: DEPTH is a power of two >= 2; push when full and pop when empty are ignored.
module a429_word_fifo #(
    parameter int DEPTH = 32,
    parameter int LEVEL = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        push,
    input  logic [31:0] din,
    input  logic        pop,
    output logic [31:0] dout,
    output logic        empty,
    output logic        at_level,
    output logic        full
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [31:0]   mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= wp + 1'b1;
            if (do_pop)  rp <= rp + 1'b1;
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end

    // Storage write.
    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    assign dout     = mem[rp];
    assign empty    = (count == '0);
    assign full     = (count == CW'(DEPTH));
    assign at_level = (count >= CW'(LEVEL));
endmodule

// File: rtl/a429_label_rx.sv
// ARINC 429 receive channel: line decoder, label/SDI/parity screen,
// receive FIFO and a four-register host port.
// Assumes: single clock domain for the host; legs are asynchronous.
module a429_label_rx
    import a429_pkg::*;
#(
    parameter int FAST_BIT_CLKS = 100,
    parameter int SLOW_BIT_CLKS = 800,
    parameter int LABELS        = 16,
    parameter int FIFO_DEPTH    = 32,
    parameter int FIFO_LEVEL    = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        leg_a,
    input  logic        leg_b,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [1:0]  reg_sel,
    input  logic [7:0]  reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        rx_empty,
    output logic        rx_level,
    output logic        rx_full,
    output logic        rx_irq
);
    localparam int PW = $clog2(LABELS + 1);

    rx_ctrl_t      ctrl;
    logic [31:0]   dec_word, fifo_dout;
    logic          dec_vld, lbl_hit, push, pop, reload;
    logic          par_ok, sdi_ok, lbl_ok;
    logic [7:0]    lbl_rdata;
    logic [PW-1:0] wr_ptr;
    reg_sel_e      sel;

    assign sel    = reg_sel_e'(reg_sel);
    assign reload = reg_wr && (sel == SEL_CTRL) && reg_wdata[7];
    assign pop    = reg_rd && (sel == SEL_DATA) && !rx_empty;

    a429_line_decoder #(
        .FAST_BIT_CLKS(FAST_BIT_CLKS),
        .SLOW_BIT_CLKS(SLOW_BIT_CLKS)
    ) u_dec (
        .clk(clk), .rst_n(rst_n), .slow(ctrl.slow),
        .leg_a(leg_a), .leg_b(leg_b),
        .word(dec_word), .word_vld(dec_vld)
    );

    a429_label_table #(.LABELS(LABELS), .PW(PW)) u_tbl (
        .clk(clk), .rst_n(rst_n), .reload(reload),
        .wr(reg_wr && (sel == SEL_LABEL)), .wdata(reg_wdata),
        .rd(reg_rd && (sel == SEL_LABEL)), .rdata(lbl_rdata),
        .probe(dec_word[7:0]), .hit(lbl_hit), .wr_ptr(wr_ptr)
    );

    // Acceptance screen applied to each completed word.
    assign par_ok = !ctrl.par_en || ((^dec_word) != ctrl.par_even);
    assign sdi_ok = !ctrl.sdi_en ||
                    ((dec_word[8] == ctrl.sdi9) && (dec_word[9] == ctrl.sdi10));
    assign lbl_ok = !ctrl.lbl_en || lbl_hit;
    assign push   = dec_vld && par_ok && sdi_ok && lbl_ok && !rx_full;

    a429_word_fifo #(.DEPTH(FIFO_DEPTH), .LEVEL(FIFO_LEVEL)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .din(dec_word),
        .pop(pop), .dout(fifo_dout),
        .empty(rx_empty), .at_level(rx_level), .full(rx_full)
    );

    // Control register; the reload bit acts as a strobe only.
    always_ff @(posedge clk) begin
        if (!rst_n)                              ctrl <= '0;
        else if (reg_wr && (sel == SEL_CTRL))    ctrl <= rx_ctrl_t'({1'b0, reg_wdata[6:0]});
    end

    // Registered read mux.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            case (sel)
                SEL_DATA:  reg_rdata <= rx_empty ? 32'd0 : fifo_dout;
                SEL_CTRL:  reg_rdata <= {24'd0, ctrl};
                SEL_STAT:  reg_rdata <= {29'd0, rx_full, rx_level, rx_empty};
                default:   reg_rdata <= {24'd0, lbl_rdata};
            endcase
        end
    end

    assign rx_irq = rx_empty || rx_level || rx_full;
endmodule

// File: rtl/a429_label_rx_chk.sv
// Checker for a429_label_rx: FIFO, screen and label-pointer properties.
// Assumes: bound to every instance of the top module.
module a429_label_rx_chk #(
    parameter int LABELS = 16,
    parameter int PW     = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_wr,
    input logic [1:0]    reg_sel,
    input logic [7:0]    reg_wdata,
    input logic          push,
    input logic          pop,
    input logic          empty,
    input logic          full,
    input logic          lbl_en,
    input logic          lbl_hit,
    input logic          par_en,
    input logic          par_even,
    input logic [31:0]   word,
    input logic [PW-1:0] wr_ptr
);
    p_full_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        full && !pop |=> full);
    p_push_room_r11: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    p_empty_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        empty && !push |=> empty);
    p_label_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        push && lbl_en |-> lbl_hit);
    p_parity_r5: assert property (@(posedge clk) disable iff (!rst_n)
        push && par_en |-> ((^word) != par_even));
    p_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && (reg_sel == 2'd1) && reg_wdata[7] |=> (wr_ptr == '0));
    p_wptr_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ptr <= PW'(LABELS));
endmodule

bind a429_label_rx a429_label_rx_chk #(.LABELS(LABELS), .PW(PW)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .push(push), .pop(pop), .empty(rx_empty),
    .full(rx_full), .lbl_en(ctrl.lbl_en), .lbl_hit(lbl_hit),
    .par_en(ctrl.par_en), .par_even(ctrl.par_even), .word(dec_word),
    .wr_ptr(wr_ptr)
);

// File: tb/test_a429_label_rx.sv
`timescale 1ns/1ps
module test_a429_label_rx;
    localparam int BT_F = 8;
    localparam int BT_S = 64;
    localparam int LBL  = 4;
    localparam int DEP  = 4;
    localparam int LVL  = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        leg_a = 1'b0, leg_b = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [7:0]  reg_wdata = 8'd0;
    logic [31:0] reg_rdata;
    logic        rx_empty, rx_level, rx_full, rx_irq;
    int          n_chk = 0, n_err = 0;
    logic [31:0] rv;

    always #2 clk = ~clk;

    a429_label_rx #(.FAST_BIT_CLKS(BT_F), .SLOW_BIT_CLKS(BT_S), .LABELS(LBL),
                    .FIFO_DEPTH(DEP), .FIFO_LEVEL(LVL)) i_a429_label_rx (
        .clk(clk), .rst_n(rst_n), .leg_a(leg_a), .leg_b(leg_b),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_empty(rx_empty),
        .rx_level(rx_level), .rx_full(rx_full), .rx_irq(rx_irq)
    );

    // {control, word, expected accept}; table holds labels 0A, 55, C3.
    localparam logic [40:0] VEC [12] = '{
        {8'h00, 32'h1234_5612, 1'b1},   // R7 compare off
        {8'h02, 32'h0ABC_DE55, 1'b1},   // R7 label present
        {8'h02, 32'h0ABC_DE12, 1'b0},   // R7 label absent
        {8'h06, 32'h8000_0055, 1'b1},   // R5 odd parity, 5 ones
        {8'h06, 32'h0000_0055, 1'b0},   // R5 odd parity, 4 ones
        {8'h0E, 32'h0000_0055, 1'b1},   // R5 even parity ok
        {8'h0E, 32'h8000_0055, 1'b0},   // R5 even parity bad
        {8'h30, 32'h0000_010A, 1'b1},   // R6 bit9=1 bit10=0
        {8'h30, 32'h0000_020A, 1'b0},   // R6 mismatch
        {8'h50, 32'h0000_020A, 1'b1},   // R6 bit10=1
        {8'h12, 32'h0000_00C3, 1'b1},   // R6 R7 combined
        {8'h01, 32'hDEAD_BEEF, 1'b1}    // R4 slow rate
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic hold(input logic a, input logic b, input int n);
        leg_a = a;
        leg_b = b;
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bits(input logic [31:0] w, input int nbits, input int bt, input bit glitch);
        for (int k = 0; k < nbits; k++) begin
            int idx = (k < 8) ? 7 - k : k;
            hold(w[idx], !w[idx], bt / 2);
            hold(1'b0, 1'b0, bt / 2);
            if (glitch) begin
                hold(1'b1, 1'b1, 2);
                hold(1'b0, 1'b0, 2);
            end
        end
    endtask

    task automatic send_word(input logic [31:0] w, input int bt);
        send_bits(w, 32, bt, 1'b0);
        hold(1'b0, 1'b0, 4 * bt);
    endtask

    task automatic wr_reg(input logic [1:0] s, input logic [7:0] d);
        reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] s, output logic [31:0] d);
        reg_rd = 1'b1; reg_sel = s;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk("R12 reset rdata", reg_rdata, 32'd0);
        chk("R12 reset irq/flags", {28'd0, rx_irq, rx_full, rx_level, rx_empty}, 32'h9);
        rd_reg(2'd1, rv); chk("R12 reset ctrl", rv, 32'd0);
        rd_reg(2'd2, rv); chk("R12 reset status", rv, 32'd1);

        // R9 load and read back labels
        wr_reg(2'd3, 8'h0A); wr_reg(2'd3, 8'h55); wr_reg(2'd3, 8'hC3);
        rd_reg(2'd3, rv); chk("R9 label rd 0", rv, 32'h0A);
        rd_reg(2'd3, rv); chk("R9 label rd 1", rv, 32'h55);
        rd_reg(2'd3, rv); chk("R9 label rd 2", rv, 32'hC3);

        // Vector table: R1 R4 R5 R6 R7
        for (int v = 0; v < 12; v++) begin
            logic [7:0]  c = VEC[v][40:33];
            logic [31:0] w = VEC[v][32:1];
            logic        a = VEC[v][0];
            wr_reg(2'd1, c);
            send_word(w, c[0] ? BT_S : BT_F);
            rd_reg(2'd2, rv);
            chk($sformatf("R1 R5 R6 R7 vec %0d status", v), rv, a ? 32'd0 : 32'd1);
            if (a) begin
                rd_reg(2'd0, rv);
                chk($sformatf("R1 R4 vec %0d data", v), rv, w);
            end
        end

        // R9 capacity: 4th entry stored, 5th ignored
        wr_reg(2'd3, 8'h99); wr_reg(2'd3, 8'h66);
        wr_reg(2'd1, 8'h02);
        send_word(32'h0000_0066, BT_F);
        chk("R9 write past end ignored", {31'd0, rx_empty}, 32'd1);
        send_word(32'h0000_0099, BT_F);
        rd_reg(2'd0, rv); chk("R9 last entry matches", rv, 32'h0000_0099);

        // R8 reload
        wr_reg(2'd1, 8'h80);
        rd_reg(2'd1, rv); chk("R8 reload bit reads 0", rv, 32'd0);
        wr_reg(2'd3, 8'h77);
        wr_reg(2'd1, 8'h02);
        send_word(32'h0ABC_DE55, BT_F);
        chk("R8 stale label ignored", {31'd0, rx_empty}, 32'd1);
        send_word(32'h0000_0077, BT_F);
        rd_reg(2'd0, rv); chk("R8 new label matches", rv, 32'h0000_0077);
        rd_reg(2'd3, rv); chk("R8 read pointer reset", rv, 32'h77);

        // R2 both-high glitches between bits
        wr_reg(2'd1, 8'h00);
        send_bits(32'hA5C3_0F81, 32, BT_F, 1'b1);
        hold(1'b0, 1'b0, 4 * BT_F);
        rd_reg(2'd0, rv); chk("R2 invalid state ignored", rv, 32'hA5C3_0F81);

        // R3 partial word discarded by gap
        send_bits(32'hFFFF_FFFF, 12, BT_F, 1'b0);
        hold(1'b0, 1'b0, 4 * BT_F);
        send_word(32'h1357_9BDF, BT_F);
        rd_reg(2'd0, rv); chk("R3 partial discarded", rv, 32'h1357_9BDF);
        rd_reg(2'd2, rv); chk("R3 only one word", rv, 32'd1);

        // R10 R11 fill, overflow, drain
        for (int i = 0; i < DEP; i++) begin
            send_word(32'h1000_0000 + i, BT_F);
            if (i == LVL - 1)
                chk("R10 level flag", {29'd0, rx_full, rx_level, rx_empty}, 32'h2);
        end
        rd_reg(2'd2, rv); chk("R10 full status", rv, 32'h6);
        chk("R10 irq when full", {31'd0, rx_irq}, 32'd1);
        send_word(32'h2222_2222, BT_F);
        for (int i = 0; i < DEP; i++) begin
            rd_reg(2'd0, rv);
            chk("R10 R11 order kept", rv, 32'h1000_0000 + i);
        end
        rd_reg(2'd0, rv); chk("R11 overflow dropped", rv, 32'd0);
        rd_reg(2'd2, rv); chk("R12 empty after drain", rv, 32'd1);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule